// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a 6-bit RF step attenuator and writes one attenuation code into it over a three-wire serial link made of a data line, a serial clock and a latch enable. A requester offers a code on a valid/ready handshake. Once the code is accepted, the block shifts the six bits out with the most significant bit first. Latch enable stays low for the whole shift. A single latch pulse then commits the word.

Each timing minimum is a parameter given in nanoseconds, together with the system clock period. The block turns each one into a cycle count, rounding up, so that no minimum is violated at any system clock rate. The minima are: serial clock high time, low time and period, data setup and hold, latch setup after the last falling clock edge, latch pulse width, and the spacing between commits.

With the default 20 ns clock the derived counts are:

| Interval | Cycles |
|---|---|
| Clock high | 2 |
| Clock low | 3 |
| Period | 5 |
| Data setup | 1 |
| Data hold | 1 |
| Latch setup | 2 |
| Latch width | 1 |
| Spacing after each commit | 2000 |

Top module: `atten_ser_master`

## Requirements
- R1: After reset, ser_clk, ser_le, busy and done are low and in_ready is high.
- R2: Each accepted code is sent as exactly 6 bits, sampled by the receiver on rising ser_clk. Bit 5 (the 16 dB weight) goes first and bit 0 (the 0.5 dB weight) goes last. The 6 bits in arrival order equal the accepted code.
- R3: ser_le is low for the whole shift and is never high together with ser_clk. Exactly one latch pulse follows each write, and it rises only after the sixth rising edge of ser_clk.
- R4: With the defaults, every ser_clk high phase lasts at least 2 cycles, every low phase before a rising edge lasts at least 3 cycles, and successive rising edges are at least 5 cycles apart.
- R5: ser_data changes only while ser_clk is low and was low in the previous cycle. It changes at least 1 cycle after a falling edge and is stable for at least 1 cycle before each rising edge.
- R6: ser_le rises at least 2 cycles after the last falling edge of ser_clk and stays high for at least 1 cycle.
- R7: in_ready returns high exactly 2000 cycles after the done pulse, and successive falling edges of ser_le are at least 2000 cycles apart.
- R8: done is a one-cycle pulse in the first cycle in which ser_le is low again after the latch pulse, with busy already low. busy is high whenever ser_clk rises.
- R9: A request presented while the block is busy or inside the spacing window waits with in_ready low. It is accepted only after the previous word has been committed, and the word sent is the code held at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request holds a code to write |
| in_ready | output | 1 | Block can accept a code this cycle |
| in_code | input | 6 | Attenuation code; bit 5 is the largest step |
| ser_clk | output | 1 | Serial clock to the attenuator, idles low |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_le | output | 1 | Latch enable to the attenuator, idles low |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse when the latch enable returns low |

## Verification
The bench models the receiving shift register and latch and checks each committed word against a scoreboard. It writes all-zero, all-one, alternating and single-bit codes. A single-high-bit code exposes a design that shifts the LSB first, because the word would arrive mirrored. The bench times every edge in system cycles. A design that changes data on the falling edge itself, raises the latch too early after the last clock, or shortens a clock phase through an off-by-one in its counters is reported with the measured interval. A pair of back-to-back requests probes the spacing window: a design that accepts the second code early, or reopens in_ready a cycle too soon or too late, breaks the 2000-cycle check or the empty-scoreboard check at acceptance.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_REST  = 3'd4,
    ST_LESU  = 3'd5,
    ST_LATCH = 3'd6
  } ser_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_ser_rst_sync.sv
module atten_ser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/atten_ser_timer.sv
module atten_ser_timer #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/atten_ser_shreg.sv
module atten_ser_shreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load) begin
      word_d = load_word;
    end else if (shift) begin
      word_d = {word_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_d;
    end
  end

  assign msb = word_q[W-1];

endmodule

// File: rtl/atten_ser_gap.sv
module atten_ser_gap #(
  parameter int GAP_CYC = 2000,
  parameter int CW      = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic open_win
);

  logic [CW-1:0] left_q;
  logic [CW-1:0] left_d;

  always_comb begin
    left_d = left_q;
    if (start) begin
      left_d = CW'(GAP_CYC);
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end

  assign open_win = (left_q == '0);

  // R7
  gap_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0 && !start) |=> (left_q == $past(left_q) - 1'b1));

  // R7
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (left_q == CW'(GAP_CYC)));

endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_ser_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYS_CLK_NS  = 20,
  parameter int T_HIGH_NS   = 30,
  parameter int T_LOW_NS    = 30,
  parameter int T_PERIOD_NS = 100,
  parameter int T_SETUP_NS  = 10,
  parameter int T_HOLD_NS   = 10,
  parameter int T_LESU_NS   = 30,
  parameter int T_LEPW_NS   = 10,
  parameter int T_GAP_NS    = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_le,
  output logic              busy,
  output logic              done
);

  localparam int CYC_HIGH  = imax(1, cdiv(T_HIGH_NS, SYS_CLK_NS));
  localparam int CYC_HOLD  = imax(1, cdiv(T_HOLD_NS, SYS_CLK_NS));
  localparam int CYC_SETUP = imax(1, cdiv(T_SETUP_NS, SYS_CLK_NS));
  localparam int CYC_LOW   = imax(imax(cdiv(T_LOW_NS, SYS_CLK_NS),
                                       cdiv(T_PERIOD_NS, SYS_CLK_NS) - CYC_HIGH),
                                  CYC_HOLD + CYC_SETUP);
  localparam int CYC_REST  = CYC_LOW - CYC_HOLD;
  localparam int CYC_LESU  = imax(cdiv(T_LESU_NS, SYS_CLK_NS), CYC_HOLD);
  localparam int CYC_LEPW  = imax(1, cdiv(T_LEPW_NS, SYS_CLK_NS));
  localparam int CYC_GAP   = cdiv(T_GAP_NS, SYS_CLK_NS);
  localparam int TMAX      = imax(imax(imax(CYC_HIGH, CYC_SETUP), imax(CYC_REST, CYC_HOLD)),
                                  imax(CYC_LESU, CYC_LEPW));
  localparam int TW        = $clog2(TMAX + 1);
  localparam int GW        = $clog2(CYC_GAP + 2);
  localparam int BW        = $clog2(CODE_W);

  logic rst_s_n;

  atten_ser_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  ser_state_e    st_q, st_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          clk_q, le_q, busy_q, done_q;
  logic          done_d;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_zero;
  logic          sh_load, sh_shift;
  logic          gap_start, gap_open;
  logic          accept;
  logic          data_bit;

  atten_ser_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load    (t_load),
    .load_val(t_val),
    .expired (t_zero)
  );

  atten_ser_shreg #(.W(CODE_W)) u_shr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (sh_load),
    .load_word(in_code),
    .shift    (sh_shift),
    .msb      (data_bit)
  );

  atten_ser_gap #(.GAP_CYC(CYC_GAP), .CW(GW)) u_gap (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .start   (gap_start),
    .open_win(gap_open)
  );

  assign in_ready = !busy_q && gap_open;
  assign accept   = in_valid && in_ready;

  // next-state process
  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    done_d    = 1'b0;
    t_load    = 1'b0;
    t_val     = '0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    gap_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_SETUP;
          t_load  = 1'b1;
          t_val   = TW'(CYC_SETUP - 1);
          sh_load = 1'b1;
          bit_d   = '0;
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          st_d   = ST_HIGH;
          t_load = 1'b1;
          t_val  = TW'(CYC_HIGH - 1);
        end
      end
      ST_HIGH: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (bit_q == BW'(CODE_W - 1)) begin
            st_d  = ST_LESU;
            t_val = TW'(CYC_LESU - 1);
          end else begin
            st_d  = ST_HOLD;
            t_val = TW'(CYC_HOLD - 1);
          end
        end
      end
      ST_HOLD: begin
        if (t_zero) begin
          st_d     = ST_REST;
          t_load   = 1'b1;
          t_val    = TW'(CYC_REST - 1);
          sh_shift = 1'b1;
          bit_d    = bit_q + 1'b1;
        end
      end
      ST_REST: begin
        if (t_zero) begin
          st_d   = ST_HIGH;
          t_load = 1'b1;
          t_val  = TW'(CYC_HIGH - 1);
        end
      end
      ST_LESU: begin
        if (t_zero) begin
          st_d   = ST_LATCH;
          t_load = 1'b1;
          t_val  = TW'(CYC_LEPW - 1);
        end
      end
      ST_LATCH: begin
        if (t_zero) begin
          st_d      = ST_IDLE;
          done_d    = 1'b1;
          gap_start = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      clk_q  <= 1'b0;
      le_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      clk_q  <= (st_d == ST_HIGH);
      le_q   <= (st_d == ST_LATCH);
      busy_q <= (st_d != ST_IDLE);
      done_q <= done_d;
    end
  end

  assign ser_clk  = clk_q;
  assign ser_le   = le_q;
  assign ser_data = data_bit;
  assign busy     = busy_q;
  assign done     = done_q;

  // R3
  le_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ser_le |-> !ser_clk);

  // R5
  data_low_only_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(ser_data) |-> (!ser_clk && !$past(ser_clk)));

  // R5
  data_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ser_clk) |-> $stable(ser_data));

  // R6
  le_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(ser_le) |-> !$past(ser_clk));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (!busy && !ser_le && $past(ser_le)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);

endmodule

// File: tb/atten_ser_master_test.sv
module atten_ser_master_test;

  localparam int SU   = 1;
  localparam int HOLD = 1;
  localparam int HI   = 2;
  localparam int LO   = 3;
  localparam int PER  = 5;
  localparam int LESU = 2;
  localparam int LEPW = 1;
  localparam int GAP  = 2000;
  localparam int NWR  = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [5:0] in_code = '0;
  logic       in_ready, ser_clk, ser_data, ser_le, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  logic [5:0] expq[$];

  always #10 clk = ~clk;

  atten_ser_master uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_code (in_code),
    .ser_clk (ser_clk),
    .ser_data(ser_data),
    .ser_le  (ser_le),
    .busy    (busy),
    .done    (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_code(input logic [5:0] code);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = code;
    forever begin
      if (in_ready) begin
        // R9: previous word must already be committed
        chk(expq.size() == 0, "R9 accept after commit", expq.size(), 0);
        expq.push_back(code);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  // monitor: receiver model plus edge timing
  logic p_clk, p_le, p_data, p_ready;
  int since_rise, since_fall, since_dchg, since_lrise, since_done, since_commit;
  int bits, frames, commits;
  logic [5:0] shv;

  always @(negedge clk) begin
    if (mon_en) begin
      bit rise, fall, lrise, lfall, dchg, rrise;
      logic [5:0] exp_w;
      rise  = ser_clk && !p_clk;
      fall  = !ser_clk && p_clk;
      lrise = ser_le && !p_le;
      lfall = !ser_le && p_le;
      dchg  = (ser_data !== p_data);
      rrise = in_ready && !p_ready;
      since_rise++; since_fall++; since_dchg++; since_lrise++;
      since_done++; since_commit++;
      if (dchg) begin
        chk(!ser_clk && !p_clk, "R5 data moved while clock high", ser_clk, 0);
        chk(since_fall >= HOLD, "R5 hold after fall", since_fall, HOLD);
      end
      if (rise) begin
        chk(!ser_le, "R3 latch low during shift", ser_le, 0);
        chk(!dchg && since_dchg >= SU, "R5 setup before rise", since_dchg, SU);
        chk(since_fall >= LO, "R4 low phase", since_fall, LO);
        if (bits > 0) chk(since_rise >= PER, "R4 period", since_rise, PER);
        chk(busy, "R8 busy during shift", busy, 1);
        chk(bits < 6, "R3 bit count", bits + 1, 6);
        shv = {shv[4:0], ser_data};
        bits++;
        since_rise = 0;
      end
      if (fall) begin
        chk(since_rise >= HI, "R4 high phase", since_rise, HI);
        since_fall = 0;
      end
      if (dchg) since_dchg = 0;
      if (lrise) begin
        chk(bits == 6, "R3 latch after sixth bit", bits, 6);
        chk(since_fall >= LESU, "R6 latch setup", since_fall, LESU);
        since_lrise = 0;
      end
      if (lfall) begin
        chk(since_lrise >= LEPW, "R6 latch width", since_lrise, LEPW);
        chk(done, "R8 done with latch fall", done, 1);
        chk(!busy, "R8 busy low at done", busy, 0);
        chk(bits == 6, "R2 six bits per word", bits, 6);
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected commit", shv, -1);
        end else begin
          exp_w = expq.pop_front();
          chk(shv == exp_w, "R2 committed word", shv, exp_w);
        end
        if (commits > 0) chk(since_commit >= GAP, "R7 commit spacing", since_commit, GAP);
        since_commit = 0;
        commits++;
        frames++;
        bits = 0;
      end
      if (done && !lfall) chk(1'b0, "R8 stray done", done, 0);
      if (done) since_done = 0;
      if (rrise && commits > 0) chk(since_done == GAP, "R7 ready reopen", since_done, GAP);
      p_clk = ser_clk; p_le = ser_le; p_data = ser_data; p_ready = in_ready;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!ser_clk, "R1 ser_clk idle", ser_clk, 0);
    chk(!ser_le, "R1 ser_le idle", ser_le, 0);
    chk(!busy, "R1 busy idle", busy, 0);
    chk(!done, "R1 done idle", done, 0);
    chk(in_ready, "R1 ready after reset", in_ready, 1);
    p_clk = ser_clk; p_le = ser_le; p_data = ser_data; p_ready = in_ready;
    since_rise = 100000; since_fall = 100000; since_dchg = 100000;
    since_lrise = 100000; since_done = 100000; since_commit = 100000;
    bits = 0; frames = 0; commits = 0; shv = '0;
    mon_en = 1'b1;
    write_code(6'h2A);
    write_code(6'h00);
    write_code(6'h3F);
    write_code(6'h20);   // R2 single MSB exposes bit order
    write_code(6'h01);
    // R9 back-to-back: second request waits through the spacing window
    write_code(6'h15);
    write_code(6'h2B);
    while (frames < NWR) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(frames == NWR, "R2 word count", frames, NWR);
    chk(expq.size() == 0, "R9 scoreboard drained", expq.size(), 0);
    chk(!busy && !ser_le && !ser_clk, "R8 idle at end", busy, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames, NWR);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule